// File: doc/BRIEF.md
# Serial Counter-Settings Scan Chain

This block receives new divider and loop settings for a frequency synthesizer over a serial link. Bits enter one per scan clock through a 144-stage shift bank, but only while the shift enable is high. The far end of the bank is brought out as a serial output, so a controller can chain or read back the stream. A separate active bank holds the settings that the synthesizer actually uses. These are five output-divider counts, one feedback count, one input-divider count and one word of loop settings, each 18 bits wide.

A rising edge on the update request starts an update. The shift bank is first captured into a holding bank. Each field then commits from the holding bank after its own parameterised latency of 1 to 8 scan clocks. This models counters that each pick up new values in step with their own clock. A busy flag rises as the update begins and falls one clock after the last field has committed. While busy is high, further update requests are ignored. The shift bank may be reloaded during an update without affecting the values being committed.

Top module: `scan_cfg_chain`

## Requirements
- R1: The shift bank has 144 stages. On each rising scan_clk edge with shift_en high it moves one place toward ser_out and takes ser_in into stage 0. ser_out shows stage 143, so after 144 enabled shifts the first bit entered is on ser_out (MSB-first).
- R2: With shift_en low the shift bank holds its content and ser_in has no effect. This is visible at ser_out and in the values a later update commits.
- R3: Stage bits [18i+17:18i] form field i. Fields 0 to 4 drive out_div[18i+17:18i], field 5 drives fb_div, field 6 drives in_div and field 7 drives loop_cfg.
- R4: An update captures the shift bank as it stands at the start edge. Shifting after that edge does not alter the committed values.
- R5: An update starts on the first clock edge at which update_req is seen high after being low, provided busy is low. busy reads high right after that edge.
- R6: Field i takes its new value exactly LAT_i edges after the start edge and keeps its old value before then. The default LAT_i is i+1, so the fields commit one at a time in order 0 to 7.
- R7: busy falls on the edge after the last field commits, which is 9 edges after the start with the default latencies. Active fields change at no other time.
- R8: A rising update_req while busy is high is ignored. An update_req held high across a whole update starts only one update.
- R9: Driving rst_n low at once clears the shift bank (ser_out 0) and busy, and loads every active field with 0x00011. Release of reset is synchronised over two scan_clk edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Scan clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| shift_en | input | 1 | Shift enable for the shift bank |
| ser_in | input | 1 | Serial data into stage 0 |
| update_req | input | 1 | Update request, acted on at its rising edge |
| ser_out | output | 1 | Last stage of the shift bank |
| busy | output | 1 | High from update start until one edge after the last commit |
| out_div | output | 90 | Five output-divider fields, field i at [18i+17:18i] |
| fb_div | output | 18 | Feedback-divider field |
| in_div | output | 18 | Input-divider field |
| loop_cfg | output | 18 | Loop-settings field |

## Verification
A wrong latency counter shows up at the ports within nine clocks of an update start. The field either takes its new value one sample early or late, or busy stays high or drops early. A corrupted shift stage only appears once that stage has reached ser_out or has been committed. For this reason every bench pattern is driven through a full update, and each field is compared on every clock of the commit window. A wrongly accepted repeat request shows up as busy rising again in the clocks just after an update ends.

// File: rtl/scan_cfg_pkg.sv
package scan_cfg_pkg;
  localparam int LAT_W = 4;
  typedef logic [LAT_W-1:0] lat_t;
endpackage

// File: rtl/scan_cfg_rst_sync.sv
module scan_cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/scan_cfg_shift_bank.sv
module scan_cfg_shift_bank #(
  parameter int LEN = 144
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           ser_in,
  output logic [LEN-1:0] bits,
  output logic           ser_out
);
  logic [LEN-1:0] sr_q, sr_d;

  // next-state: move toward the output end, new bit at stage 0
  always_comb begin
    sr_d = {sr_q[LEN-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  assign bits    = sr_q;
  assign ser_out = sr_q[LEN-1];

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q)); // R2
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> ser_out == $past(sr_q[LEN-2])); // R1
endmodule

// File: rtl/scan_cfg_field_commit.sv
module scan_cfg_field_commit import scan_cfg_pkg::*; #(
  parameter int           W    = 18,
  parameter lat_t         LAT  = lat_t'(1),
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] field,
  output logic         pend
);
  logic         pend_q, pend_d;
  lat_t         cnt_q, cnt_d;
  logic [W-1:0] val_q;
  logic         commit;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    commit = pend_q && (cnt_q == '0);
    if (start) begin
      pend_d = 1'b1;
      cnt_d  = lat_t'(LAT - 1'b1);
    end else if (pend_q) begin
      if (cnt_q == '0) pend_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= INIT;
    else if (commit) val_q <= cap_val;
  end

  assign field = val_q;
  assign pend  = pend_q;

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(val_q)); // R7
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> pend_q); // R6
endmodule

// File: rtl/scan_cfg_chain.sv
module scan_cfg_chain import scan_cfg_pkg::*; #(
  parameter int                       NUM_OUT    = 5,
  parameter int                       FIELD_W    = 18,
  parameter logic [LAT_W*(NUM_OUT+3)-1:0] FIELD_LAT = 32'h8765_4321,
  parameter logic [FIELD_W-1:0]       FIELD_INIT = FIELD_W'(17)
) (
  input  logic                       scan_clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic                       ser_in,
  input  logic                       update_req,
  output logic                       ser_out,
  output logic                       busy,
  output logic [NUM_OUT*FIELD_W-1:0] out_div,
  output logic [FIELD_W-1:0]         fb_div,
  output logic [FIELD_W-1:0]         in_div,
  output logic [FIELD_W-1:0]         loop_cfg
);
  localparam int NUM_FIELDS = NUM_OUT + 3;
  localparam int CHAIN_LEN  = NUM_FIELDS * FIELD_W;
  localparam int FB_LO      = NUM_OUT * FIELD_W;
  localparam int IN_LO      = FB_LO + FIELD_W;
  localparam int LOOP_LO    = IN_LO + FIELD_W;

  logic                  rst_q_n;
  logic [CHAIN_LEN-1:0]  sr_bits;
  logic [CHAIN_LEN-1:0]  cap_q;
  logic [CHAIN_LEN-1:0]  active;
  logic [NUM_FIELDS-1:0] pend;
  logic                  upd_q;
  logic                  busy_q, busy_d;
  logic                  start;

  scan_cfg_rst_sync u_rst (
    .clk    (scan_clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  scan_cfg_shift_bank #(.LEN(CHAIN_LEN)) u_shift (
    .clk     (scan_clk),
    .rst_n   (rst_q_n),
    .shift_en(shift_en),
    .ser_in  (ser_in),
    .bits    (sr_bits),
    .ser_out (ser_out)
  );

  always_comb begin
    start  = update_req && !upd_q && !busy_q;
    busy_d = busy_q;
    if (start)                 busy_d = 1'b1;
    else if (busy_q && !(|pend)) busy_d = 1'b0;
  end

  always_ff @(posedge scan_clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      upd_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      upd_q  <= update_req;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge scan_clk or negedge rst_q_n) begin
    if (!rst_q_n)   cap_q <= '0;
    else if (start) cap_q <= sr_bits;
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    scan_cfg_field_commit #(
      .W   (FIELD_W),
      .LAT (lat_t'(FIELD_LAT[gi*LAT_W +: LAT_W])),
      .INIT(FIELD_INIT)
    ) u_field (
      .clk    (scan_clk),
      .rst_n  (rst_q_n),
      .start  (start),
      .cap_val(cap_q[gi*FIELD_W +: FIELD_W]),
      .field  (active[gi*FIELD_W +: FIELD_W]),
      .pend   (pend[gi])
    );
  end

  assign busy     = busy_q;
  assign out_div  = active[FB_LO-1:0];
  assign fb_div   = active[FB_LO +: FIELD_W];
  assign in_div   = active[IN_LO +: FIELD_W];
  assign loop_cfg = active[LOOP_LO +: FIELD_W];

  AST_BUSY_ON_START: assert property (@(posedge scan_clk) disable iff (!rst_q_n)
    ($rose(update_req) && !busy_q) |=> busy_q); // R5
  AST_PEND_COVERED: assert property (@(posedge scan_clk) disable iff (!rst_q_n)
    (|pend) |-> busy_q); // R7
  AST_IGNORE_BUSY: assert property (@(posedge scan_clk) disable iff (!rst_q_n)
    (busy_q && $rose(update_req)) |=> $stable(cap_q)); // R8
endmodule

// File: tb/scan_cfg_chain_bench.sv
module scan_cfg_chain_bench;
  localparam int NF = 8;
  localparam int FW = 18;
  localparam int CL = NF * FW;
  localparam logic [FW-1:0] INIT_V = 18'h00011;

  typedef struct packed {
    logic [FW-1:0] seed;
    logic          first_bit;
  } vec_t;

  // stimulus seed and expected ser_out after a full load (bit 17 of field 7)
  localparam vec_t VEC [4] = '{
    '{18'h00000, 1'b0},
    '{18'h2AAAA, 1'b1},
    '{18'h15555, 1'b1},
    '{18'h3C0F1, 1'b0}
  };

  logic scan_clk = 1'b0;
  logic rst_n, shift_en, ser_in, update_req;
  logic ser_out, busy;
  logic [5*FW-1:0] out_div;
  logic [FW-1:0] fb_div, in_div, loop_cfg;

  int n_chk = 0;
  int n_fail = 0;
  logic [FW-1:0] cur_f [NF];
  logic [FW-1:0] new_f [NF];

  always #2 scan_clk = ~scan_clk;

  scan_cfg_chain u_scan_cfg_chain (
    .scan_clk(scan_clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
    .update_req(update_req), .ser_out(ser_out), .busy(busy),
    .out_div(out_div), .fb_div(fb_div), .in_div(in_div), .loop_cfg(loop_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] get_f(input int i);
    if (i < 5)       return out_div[i*FW +: FW];
    else if (i == 5) return fb_div;
    else if (i == 6) return in_div;
    else             return loop_cfg;
  endfunction

  function automatic logic [CL-1:0] mk_pat(input logic [FW-1:0] seed);
    logic [CL-1:0] p;
    for (int i = 0; i < NF; i++) p[i*FW +: FW] = seed + FW'(i) * 18'h0247B;
    return p;
  endfunction

  task automatic set_new(input logic [CL-1:0] p);
    for (int i = 0; i < NF; i++) new_f[i] = p[i*FW +: FW];
  endtask

  task automatic check_all(input string req, input logic [FW-1:0] exp_f [NF]);
    for (int i = 0; i < NF; i++) chk(req, 32'(get_f(i)), 32'(exp_f[i]));
  endtask

  task automatic shift_pat(input logic [CL-1:0] p);
    for (int j = CL - 1; j >= 0; j--) begin
      @(negedge scan_clk);
      shift_en = 1'b1;
      ser_in   = p[j];
    end
    @(negedge scan_clk);
    shift_en = 1'b0;
    ser_in   = 1'b0;
  endtask

  // R5 R6 R7: per-clock check of commit order and busy window
  task automatic run_update();
    @(negedge scan_clk);
    update_req = 1'b1;
    @(negedge scan_clk);
    update_req = 1'b0;
    for (int k = 0; k <= 9; k++) begin
      if (k > 0) @(negedge scan_clk);
      chk("R5/R7 busy", 32'(busy), 32'(k <= 8));
      for (int i = 0; i < NF; i++)
        chk("R6 commit", 32'(get_f(i)), 32'((k >= i + 1) ? new_f[i] : cur_f[i]));
    end
    for (int i = 0; i < NF; i++) cur_f[i] = new_f[i];
  endtask

  initial begin
    repeat (200000) @(posedge scan_clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [CL-1:0] pat;
    rst_n = 1'b0; shift_en = 1'b0; ser_in = 1'b0; update_req = 1'b0;
    for (int i = 0; i < NF; i++) cur_f[i] = INIT_V;
    repeat (3) @(negedge scan_clk);
    // R9 reset state
    chk("R9 busy", 32'(busy), 0);
    chk("R9 ser_out", 32'(ser_out), 0);
    check_all("R9 init", cur_f);
    rst_n = 1'b1;
    repeat (3) @(negedge scan_clk);

    // table walk: R1 R3 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      pat = mk_pat(VEC[v].seed);
      shift_pat(pat);
      chk("R1 ser_out", 32'(ser_out), 32'(VEC[v].first_bit));
      set_new(pat);
      run_update();
      check_all("R3 layout", cur_f);
    end

    // R2: toggling ser_in with shift_en low changes nothing
    for (int j = 0; j < 30; j++) begin
      @(negedge scan_clk);
      ser_in = ~ser_in;
    end
    @(negedge scan_clk);
    ser_in = 1'b0;
    chk("R2 ser_out", 32'(ser_out), 32'(VEC[3].first_bit));
    set_new(mk_pat(VEC[3].seed));
    run_update();
    check_all("R2 unchanged", cur_f);

    // R4: shifting during an update does not change committed values
    pat = mk_pat(18'h1F00F);
    shift_pat(pat);
    set_new(pat);
    @(negedge scan_clk);
    update_req = 1'b1;
    @(negedge scan_clk);
    update_req = 1'b0;
    shift_en = 1'b1;
    ser_in = 1'b1;
    repeat (12) @(negedge scan_clk);
    shift_en = 1'b0;
    ser_in = 1'b0;
    check_all("R4 snapshot", new_f);
    for (int i = 0; i < NF; i++) cur_f[i] = new_f[i];

    // R8: rising request while busy is ignored
    pat = mk_pat(18'h0ABCD);
    shift_pat(pat);
    set_new(pat);
    @(negedge scan_clk);
    update_req = 1'b1;
    @(negedge scan_clk);
    update_req = 1'b0;
    @(negedge scan_clk);
    @(negedge scan_clk);
    update_req = 1'b1;
    @(negedge scan_clk);
    update_req = 1'b0;
    for (int k = 3; k <= 13; k++) begin
      if (k > 3) @(negedge scan_clk);
      chk("R8 busy", 32'(busy), 32'(k <= 8));
    end
    check_all("R8 values", new_f);
    for (int i = 0; i < NF; i++) cur_f[i] = new_f[i];

    // R8: held request starts only one update
    @(negedge scan_clk);
    update_req = 1'b1;
    for (int k = 0; k <= 20; k++) begin
      @(negedge scan_clk);
      chk("R8 held busy", 32'(busy), 32'(k <= 8));
    end
    update_req = 1'b0;

    // R9: asynchronous reset in the middle of an update
    pat = mk_pat(18'h33333);
    shift_pat(pat);
    @(negedge scan_clk);
    update_req = 1'b1;
    @(negedge scan_clk);
    update_req = 1'b0;
    @(negedge scan_clk);
    @(negedge scan_clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < NF; i++) cur_f[i] = INIT_V;
    chk("R9 busy async", 32'(busy), 0);
    chk("R9 ser_out async", 32'(ser_out), 0);
    check_all("R9 fields async", cur_f);
    @(negedge scan_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge scan_clk);
    chk("R9 after release", 32'(busy), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule